// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Multiplier

This block is a multi-cycle integer multiplier for a 32-bit processor core. It supports six forms: a 32x32 multiply that keeps the low 32 bits, the same multiply with a 32-bit addend, and unsigned and signed 32x32 to 64-bit multiplies, each with or without a 64-bit addend. The block walks the second operand (the multiplier) one 8-bit digit per cycle. It stops as soon as the remaining upper digits carry no information: either they are all zero, or, for sign-aware forms, they are all ones. Short multipliers therefore finish in fewer cycles.

The surrounding core presents both operands, an operation code and a one-cycle start strobe. It holds the addend inputs steady until the done strobe. Two addend halves are taken in separate cycles, which gives the accumulating forms their extra latency. The result is valid in the cycle where `done_o` is high. It stays on the outputs until the next operation is accepted. A new operation may start in the same cycle that the previous one reports done, so operations can run back to back.

Top module: `mulit_top`

## Requirements
- R1: Operation code 0 returns the low 32 bits of opa*opb on `res_lo_o`. Code 1 returns the low 32 bits of opa*opb+acc_lo. For both codes `res_hi_o` is 0.
- R2: Code 2 returns the 64-bit unsigned product {res_hi_o,res_lo_o}. Code 3 returns that product plus the 64-bit unsigned value {acc_hi,acc_lo}, taken modulo 2^64.
- R3: Code 4 returns the 64-bit two's-complement product. Code 5 returns that product plus {acc_hi,acc_lo}, taken modulo 2^64.
- R4: The digit count m is the smallest k in 1..3 for which opb[31:8k] is all zeros or all ones, and 4 if there is none. For codes 2 and 3, only an all-zero upper part counts.
- R5: If start is sampled at clock edge E, `done_o` is high only in the N-th cycle after E. N is 1+m for code 0, 2+m for codes 1, 2 and 4, and 3+m for codes 3 and 5.
- R6: `busy_o` is high in cycles 1..N-1 and low in the done cycle. `done_o` is a single-cycle pulse. Both outputs are low in the cycle after the done cycle unless a new operation starts.
- R7: A start strobe sampled while `busy_o` is high is ignored. The running operation keeps its result and its cycle count.
- R8: A start strobe sampled in the done cycle is accepted. The new operation then follows R5 from that edge.
- R9: `zero_o` and `neg_o` are valid in the done cycle. For codes 0 and 1 they report whether the 32-bit result is zero and show bit 31 of that result. For codes 2 to 5 they report whether the 64-bit result is zero and show bit 63.
- R10: After reset, `busy_o` and `done_o` are low, both result words are 0, `zero_o` is 1 and `neg_o` is 0.
- R11: Codes 6 and 7 behave exactly like code 0, both in result and in cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; accepted when idle or in the done cycle |
| op_i | input | 3 | Operation code (see R1, R2, R3, R11) |
| opa_i | input | 32 | Multiplicand |
| opb_i | input | 32 | Multiplier; sets the digit count m |
| acc_lo_i | input | 32 | Low addend word; held from start to done |
| acc_hi_i | input | 32 | High addend word; held from start to done |
| busy_o | output | 1 | Operation in progress, excluding the done cycle |
| done_o | output | 1 | Result valid this cycle |
| res_lo_o | output | 32 | Result bits 31:0 |
| res_hi_o | output | 32 | Result bits 63:32 (0 for 32-bit forms) |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result sign bit |

## Verification
The two functions that can coincide are the report of one result and the acceptance of the next operation. Both happen in the done cycle. The bench drives a new start, with different operands, in the exact cycle where it expects the first operation's done pulse. It checks the first result in that cycle. It then checks that the second operation completes with its own expected product after precisely its own N cycles. A similar overlap is provoked one cycle earlier: the bench pulses a strobe carrying junk operands in the first busy cycle. That strobe must leave both the running product and its done cycle untouched.

// File: rtl/mulit_pkg.sv
package mulit_pkg;

    // Operation codes seen on op_i. Codes 6 and 7 fold onto OP_MUL.
    typedef enum logic [2:0] {
        OP_MUL   = 3'd0,
        OP_MLA   = 3'd1,
        OP_UMULL = 3'd2,
        OP_UMLAL = 3'd3,
        OP_SMULL = 3'd4,
        OP_SMLAL = 3'd5
    } mop_e;

    // Controller phases
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ACCLO = 3'd1,
        ST_ACCHI = 3'd2,
        ST_ITER  = 3'd3,
        ST_FIN   = 3'd4
    } mst_e;

    // Properties of one operation form
    typedef struct packed {
        logic acc;   // adds an addend
        logic lng;   // 64-bit result
        logic sgn;   // sign-aware early termination and correction
    } mform_t;

endpackage

// File: rtl/mulit_opdec.sv
module mulit_opdec
    import mulit_pkg::*;
(
    input  logic [2:0] op_i,
    output mform_t     form_o
);

    always_comb begin
        form_o = '{acc: 1'b0, lng: 1'b0, sgn: 1'b1};
        case (op_i)
            OP_MLA:   form_o = '{acc: 1'b1, lng: 1'b0, sgn: 1'b1};
            OP_UMULL: form_o = '{acc: 1'b0, lng: 1'b1, sgn: 1'b0};
            OP_UMLAL: form_o = '{acc: 1'b1, lng: 1'b1, sgn: 1'b0};
            OP_SMULL: form_o = '{acc: 1'b0, lng: 1'b1, sgn: 1'b1};
            OP_SMLAL: form_o = '{acc: 1'b1, lng: 1'b1, sgn: 1'b1};
            default:  form_o = '{acc: 1'b0, lng: 1'b0, sgn: 1'b1};
        endcase
    end

endmodule

// File: rtl/mulit_mdec.sv
module mulit_mdec #(
    parameter int XLEN = 32,
    parameter int DIG  = 8,
    parameter int NDIG = XLEN / DIG,
    parameter int MW   = $clog2(NDIG + 1)
) (
    input  logic [XLEN-1:0] b_i,
    input  logic            uns_i,
    output logic [MW-1:0]   m_o
);

    // fits[k]: everything from digit k upward is pure extension
    logic [NDIG-1:1] fits;

    genvar k;
    generate
        for (k = 1; k < NDIG; k++) begin : g_fit
            assign fits[k] = (b_i[XLEN-1:k*DIG] == '0) ||
                             (!uns_i && (&b_i[XLEN-1:k*DIG]));
        end
    endgenerate

    always_comb begin
        m_o = MW'(NDIG);
        for (int j = NDIG - 1; j >= 1; j--) begin
            if (fits[j]) m_o = MW'(j);
        end
    end

endmodule

// File: rtl/mulit_step.sv
module mulit_step #(
    parameter int XLEN = 32,
    parameter int DIG  = 8,
    parameter int IW   = 2,
    parameter int PW   = 2 * XLEN
) (
    input  logic [PW-1:0]  sum_i,
    input  logic [PW-1:0]  mc_i,
    input  logic [DIG-1:0] dig_i,
    input  logic [IW-1:0]  idx_i,
    input  logic           last_i,
    input  logic           negx_i,
    output logic [PW-1:0]  sum_o
);

    logic [PW-1:0] pp;
    logic [PW-1:0] pp_sh;
    logic [PW-1:0] corr;

    // digit treated as unsigned; a negative multiplier is repaired on
    // the final digit by removing one multiplicand weight 2^(DIG*m)
    assign pp    = mc_i * PW'(dig_i);
    assign pp_sh = pp << (DIG * int'(idx_i));
    assign corr  = (last_i && negx_i) ? (mc_i << (DIG * (int'(idx_i) + 1))) : '0;
    assign sum_o = sum_i + pp_sh - corr;

endmodule

// File: rtl/mulit_top.sv
module mulit_top
    import mulit_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int DIG  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [2:0]      op_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [XLEN-1:0] acc_lo_i,
    input  logic [XLEN-1:0] acc_hi_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] res_lo_o,
    output logic [XLEN-1:0] res_hi_o,
    output logic            zero_o,
    output logic            neg_o
);

    localparam int NDIG = XLEN / DIG;
    localparam int MW   = $clog2(NDIG + 1);
    localparam int IW   = $clog2(NDIG);
    localparam int PW   = 2 * XLEN;

    typedef struct packed {
        mst_e            st;
        mform_t          form;
        logic [PW-1:0]   mc;
        logic [XLEN-1:0] b;
        logic [MW-1:0]   m;
        logic [IW-1:0]   idx;
        logic [PW-1:0]   sum;
    } mstate_t;

    mstate_t s_q, s_d;

    mform_t        new_form;
    logic [MW-1:0] new_m;
    logic [PW-1:0] step_sum;
    logic [DIG-1:0] cur_dig;
    logic [MW-1:0] idx_next;
    logic          last_dig;
    logic          negx;
    logic          accept;

    mulit_opdec u_opdec (
        .op_i   (op_i),
        .form_o (new_form)
    );

    mulit_mdec #(.XLEN(XLEN), .DIG(DIG), .NDIG(NDIG), .MW(MW)) u_mdec (
        .b_i   (opb_i),
        .uns_i (!new_form.sgn),
        .m_o   (new_m)
    );

    assign cur_dig  = s_q.b[int'(s_q.idx)*DIG +: DIG];
    assign idx_next = MW'(s_q.idx) + MW'(1);
    assign last_dig = (idx_next == s_q.m);
    assign negx     = s_q.form.sgn & s_q.b[XLEN-1];

    mulit_step #(.XLEN(XLEN), .DIG(DIG), .IW(IW), .PW(PW)) u_step (
        .sum_i  (s_q.sum),
        .mc_i   (s_q.mc),
        .dig_i  (cur_dig),
        .idx_i  (s_q.idx),
        .last_i (last_dig),
        .negx_i (negx),
        .sum_o  (step_sum)
    );

    assign accept = start_i && ((s_q.st == ST_IDLE) || (s_q.st == ST_FIN));

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_ACCLO: begin
                s_d.sum[XLEN-1:0] = acc_lo_i;
                s_d.st = s_q.form.lng ? ST_ACCHI : ST_ITER;
            end
            ST_ACCHI: begin
                s_d.sum[PW-1:XLEN] = s_q.form.acc ? acc_hi_i : '0;
                s_d.st = ST_ITER;
            end
            ST_ITER: begin
                s_d.sum = step_sum;
                s_d.idx = s_q.idx + 1'b1;
                if (last_dig) s_d.st = ST_FIN;
            end
            ST_FIN:  s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
        if (accept) begin
            s_d.form = new_form;
            s_d.mc   = (new_form.sgn && new_form.lng) ?
                       {{XLEN{opa_i[XLEN-1]}}, opa_i} : {{XLEN{1'b0}}, opa_i};
            s_d.b    = opb_i;
            s_d.m    = new_m;
            s_d.idx  = '0;
            s_d.sum  = '0;
            s_d.st   = new_form.acc ? ST_ACCLO :
                       (new_form.lng ? ST_ACCHI : ST_ITER);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o   = (s_q.st == ST_ACCLO) || (s_q.st == ST_ACCHI) || (s_q.st == ST_ITER);
    assign done_o   = (s_q.st == ST_FIN);
    assign res_lo_o = s_q.sum[XLEN-1:0];
    assign res_hi_o = s_q.form.lng ? s_q.sum[PW-1:XLEN] : '0;
    assign zero_o   = s_q.form.lng ? (s_q.sum == '0) : (s_q.sum[XLEN-1:0] == '0);
    assign neg_o    = s_q.form.lng ? s_q.sum[PW-1] : s_q.sum[XLEN-1];

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    logic [7:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_q <= '0;
        else if (accept) lat_q <= 8'd1;
        else if (busy_o) lat_q <= lat_q + 8'd1;
    end

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(lat_q) == 1 + int'(s_q.m) + int'(s_q.form.acc) + int'(s_q.form.lng)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_m_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (s_q.m != '0 && int'(s_q.m) <= NDIG));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(s_q.b) && $stable(s_q.mc) && $stable(s_q.form)));

    assert_hi_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !s_q.form.lng) |-> (res_hi_o == '0));

endmodule

// File: tb/mulit_top_tb.sv
module mulit_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [2:0]  op_i;
    logic [31:0] opa_i, opb_i, acc_lo_i, acc_hi_i;
    logic        busy_o, done_o, zero_o, neg_o;
    logic [31:0] res_lo_o, res_hi_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    mulit_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .acc_lo_i(acc_lo_i), .acc_hi_i(acc_hi_i),
        .busy_o(busy_o), .done_o(done_o), .res_lo_o(res_lo_o), .res_hi_o(res_hi_o),
        .zero_o(zero_o), .neg_o(neg_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] norm(input logic [2:0] op);
        return (op > 3'd5) ? 3'd0 : op;
    endfunction

    function automatic string req_of(input logic [2:0] op);
        if (op > 3'd5) return "R11";
        if (op <= 3'd1) return "R1";
        if (op <= 3'd3) return "R2";
        return "R3";
    endfunction

    // R4 reference
    function automatic int m_ref(input logic [31:0] b, input bit uns);
        for (int k = 1; k < 4; k++) begin
            logic [31:0] hi;
            hi = b >> (8 * k);
            if (hi == 32'd0) return k;
            if (!uns && hi == (32'hFFFF_FFFF >> (8 * k))) return k;
        end
        return 4;
    endfunction

    // R5 reference
    function automatic int lat_ref(input logic [2:0] op, input logic [31:0] b);
        logic [2:0] o;
        int n;
        o = norm(op);
        n = 1 + m_ref(b, (o == 3'd2) || (o == 3'd3));
        if (o == 3'd1 || o == 3'd3 || o == 3'd5) n++;
        if (o >= 3'd2) n++;
        return n;
    endfunction

    function automatic logic [63:0] res_ref(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] lo,
                                            input logic [31:0] hi);
        logic [31:0] p32;
        logic signed [63:0] sa, sb;
        case (norm(op))
            3'd0: begin p32 = a * b; return {32'd0, p32}; end
            3'd1: begin p32 = a * b + lo; return {32'd0, p32}; end
            3'd2: return {32'd0, a} * {32'd0, b};
            3'd3: return {32'd0, a} * {32'd0, b} + {hi, lo};
            3'd4: begin sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b}; return sa * sb; end
            default: begin
                sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
                return sa * sb + {hi, lo};
            end
        endcase
    endfunction

    // drive an operation at a falling edge; it is sampled at the next rising edge
    task automatic launch(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] lo, input logic [31:0] hi);
        op_i = op; opa_i = a; opb_i = b; acc_lo_i = lo; acc_hi_i = hi;
        start_i = 1'b1;
    endtask

    // cycle-by-cycle comparison against the reference until the done cycle
    task automatic follow(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] lo, input logic [31:0] hi, input bit junk,
                          input string tag);
        int n;
        logic [63:0] e;
        bit lng;
        n   = lat_ref(op, b);
        e   = res_ref(op, a, b, lo, hi);
        lng = norm(op) >= 3'd2;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i < n) begin
                chk(busy_o == 1'b1, "R6", {tag, " busy in working cycle"}, 64'(busy_o), 64'd1);
                chk(done_o == 1'b0, "R4 R5", {tag, " no early done"}, 64'(done_o), 64'd0);
            end else begin
                chk(done_o == 1'b1, "R4 R5", {tag, " done on expected cycle"}, 64'(done_o), 64'd1);
                chk(busy_o == 1'b0, "R6", {tag, " busy low in done cycle"}, 64'(busy_o), 64'd0);
                chk({res_hi_o, res_lo_o} == e, req_of(op), {tag, " result"},
                    {res_hi_o, res_lo_o}, e);
                chk(zero_o == (lng ? (e == 64'd0) : (e[31:0] == 32'd0)), "R9",
                    {tag, " zero flag"}, 64'(zero_o), 64'(lng ? (e == 64'd0) : (e[31:0] == 32'd0)));
                chk(neg_o == (lng ? e[63] : e[31]), "R9", {tag, " neg flag"},
                    64'(neg_o), 64'(lng ? e[63] : e[31]));
            end
            if (i == 1 && junk) begin
                // R7: junk strobe in a busy cycle
                start_i = 1'b1;
                op_i  = 3'($urandom);
                opa_i = $urandom;
                opb_i = $urandom;
            end else begin
                start_i = 1'b0;
            end
        end
    endtask

    task automatic idle_chk(input string tag);
        @(posedge clk);
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R6", {tag, " idle after done"},
            {62'd0, busy_o, done_o}, 64'd0);
    endtask

    task automatic one(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] lo, input logic [31:0] hi, input string tag);
        launch(op, a, b, lo, hi);
        follow(op, a, b, lo, hi, 1'b0, tag);
        idle_chk(tag);
    endtask

    logic [31:0] bvals [8];
    logic [31:0] avals [4];

    initial begin
        bvals = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FF00,
                  32'h0001_2345, 32'h0000_007F, 32'hFFFF_8000, 32'h00FF_FFFF};
        avals = '{32'h0000_0003, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
        rst_n = 1'b0; start_i = 1'b0; op_i = '0;
        opa_i = '0; opb_i = '0; acc_lo_i = '0; acc_hi_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(busy_o == 1'b0, "R10", "busy after reset", 64'(busy_o), 64'd0);
        chk(done_o == 1'b0, "R10", "done after reset", 64'(done_o), 64'd0);
        chk({res_hi_o, res_lo_o} == 64'd0, "R10", "result after reset", {res_hi_o, res_lo_o}, 64'd0);
        chk(zero_o == 1'b1 && neg_o == 1'b0, "R10", "flags after reset",
            {62'd0, zero_o, neg_o}, 64'd2);

        // directed: every form against extreme multipliers (R1 R2 R3 R4 R5)
        for (int op = 0; op < 6; op++) begin
            for (int bi = 0; bi < 8; bi++) begin
                one(3'(op), avals[bi % 4], bvals[bi], 32'hDEAD_BEEF, 32'h8765_4321, "directed");
            end
        end

        // R9 flag corners
        one(3'd0, 32'h0001_0000, 32'h0001_0000, 32'd0, 32'd0, "wrap to zero");
        one(3'd4, 32'hFFFF_FFFF, 32'h0000_0001, 32'd0, 32'd0, "signed negative");
        one(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0, "unsigned max");
        one(3'd5, 32'h0000_0001, 32'hFFFF_FFFF, 32'd1, 32'd0, "signed acc to zero");

        // R11 spare codes
        one(3'd6, 32'h0000_1234, 32'hFFFF_FF80, 32'd0, 32'd0, "R11 code 6");
        one(3'd7, 32'h8000_0001, 32'h0012_3456, 32'd0, 32'd0, "R11 code 7");

        // R7 start while busy
        launch(3'd3, 32'h0BAD_F00D, 32'h0000_00C3, 32'h1111_1111, 32'h2222_2222);
        follow(3'd3, 32'h0BAD_F00D, 32'h0000_00C3, 32'h1111_1111, 32'h2222_2222, 1'b1, "R7 junk");
        idle_chk("R7 junk");
        launch(3'd0, 32'h0000_0005, 32'h0000_0007, 32'd0, 32'd0);
        follow(3'd0, 32'h0000_0005, 32'h0000_0007, 32'd0, 32'd0, 1'b1, "R7 junk short");
        idle_chk("R7 junk short");

        // R8 back to back: new start in the done cycle
        launch(3'd5, 32'hFFFF_FFF0, 32'h7FFF_FFFF, 32'h0000_0010, 32'hFFFF_FFFF);
        follow(3'd5, 32'hFFFF_FFF0, 32'h7FFF_FFFF, 32'h0000_0010, 32'hFFFF_FFFF, 1'b0, "R8 first");
        launch(3'd0, 32'h0000_0009, 32'h0000_000B, 32'd0, 32'd0);
        follow(3'd0, 32'h0000_0009, 32'h0000_000B, 32'd0, 32'd0, 1'b0, "R8 second");
        launch(3'd2, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'd0, 32'd0);
        follow(3'd2, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'd0, 32'd0, 1'b0, "R8 third");
        idle_chk("R8 tail");

        // random operands with shaped multiplier magnitude
        for (int r = 0; r < 300; r++) begin
            logic [2:0]  op;
            logic [31:0] a, b, lo, hi;
            int sh;
            op = 3'($urandom_range(0, 7));
            a  = $urandom;
            sh = $urandom_range(0, 3);
            b  = $urandom >> (8 * sh);
            if ($urandom_range(0, 1) == 1) b = ~b;
            lo = $urandom;
            hi = $urandom;
            launch(op, a, b, lo, hi);
            follow(op, a, b, lo, hi, (r % 7) == 0, "random");
            if ((r % 3) != 0) idle_chk("random");
        end
        start_i = 1'b0;
        idle_chk("final");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule